// File: doc/BRIEF.md
# Windowed Address Target Decoder

This block steers each transaction address to a destination identifier. A bank of programmable windows each describes an inclusive span of 1 MiB blocks, an enable, a destination identifier and two security attributes. A 48-bit address presented on the decode port is compared against every window at once. The lowest-numbered enabled window whose span contains the address supplies the destination, the window number and the security flags. Traffic that no window claims goes to the destination held in a single global fallback register.

Software programs the windows through a plain 32-bit register port. Writes take effect on the clock edge, and reads are combinational. Each window occupies four consecutive word slots: control, security, lower bound and upper bound. The fallback register follows the last window. Window 0 is a fixed configuration-space window. It is decoded from reset, and writes cannot disturb it.

Top module: `addr_window_router`

## Requirements
- R1: After reset, window 0 control reads 0x000000F1 (enable set, destination 0x0F), its lower bound reads 0xF0000000 and its upper bound reads 0xF00000F0. Every other window control reads 0 and the fallback register (word 32) reads 0.
- R2: Register word index is window*4 + slot, where slot 0 is control, 1 is security, 2 is the lower bound and 3 is the upper bound. Only the implemented bits read back: control bit 0 and bits [11:4], security bits [1:0], and bound bits [31:4]. All other bits read as zero.
- R3: A window whose control bit 0 is clear never produces a hit.
- R4: An address hits a window when its bits [47:20] are at least the lower bound bits [31:4] and at most the upper bound bits [31:4]. On a hit, dec_hit is 1, dec_target equals control bits [11:4] and dec_win gives the window number.
- R5: When no window hits, dec_hit is 0, dec_target equals fallback register bits [7:0], dec_win is 0, and both security outputs are 0.
- R6: When several enabled windows contain the address, the lowest-numbered one is reported.
- R7: A window whose upper bound is below its lower bound never produces a hit.
- R8: On a hit, dec_wr_secure reports security bit 0 of the matched window and dec_rd_secure reports security bit 1.
- R9: Writes to window 0 registers (words 0 to 3) are ignored. Addresses in blocks 0xF000000 to 0xF00000F always hit window 0 unless shadowed by nothing lower, with destination 0x0F.
- R10: A register write becomes visible on the decode outputs and in the read data only after the clock edge on which it is presented. The decode path itself is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| dec_addr | input | 48 | Address to decode |
| dec_target | output | 8 | Selected destination identifier |
| dec_hit | output | 1 | Some enabled window contains dec_addr |
| dec_win | output | 3 | Number of the reporting window, 0 on a miss |
| dec_wr_secure | output | 1 | Write-secure attribute of the matched window |
| dec_rd_secure | output | 1 | Read-secure attribute of the matched window |

## Verification
The assertions sample the combinational decode at the rising edge. They therefore assume that dec_addr and the register port settle before that edge. The stimulus changes every input just after a falling edge and samples outputs within the low half of the clock. The write-visibility property also assumes that a fallback-register write carries its destination in bits [7:0], and the bench always writes it that way. Overlap, inverted-bound and disabled windows are built by explicit programming sequences, so every priority outcome is reached on purpose.

// File: rtl/awr_pkg.sv
package awr_pkg;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_SEC  = 2'd1,
    SLOT_LO   = 2'd2,
    SLOT_HI   = 2'd3
  } slot_e;

  // Inclusive block-span test; an inverted span can never be satisfied.
  function automatic logic blk_in_span(input logic en, input logic [31:0] lo,
                                       input logic [31:0] hi, input logic [31:0] blk);
    return en && (blk >= lo) && (blk <= hi);
  endfunction

endpackage

// File: rtl/awr_regfile.sv
module awr_regfile #(
  parameter int NUM_WIN = 8,
  parameter int BLK_W   = 28,
  parameter int TGT_W   = 8,
  parameter int TGT_LSB = 4,
  parameter int REG_AW  = 6,
  parameter logic [TGT_W-1:0] CFG_TGT    = 8'h0F,
  parameter logic [BLK_W-1:0] CFG_LO_BLK = 28'hF000000,
  parameter logic [BLK_W-1:0] CFG_HI_BLK = 28'hF00000F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [REG_AW-1:0]        addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output logic [NUM_WIN-1:0]       win_en,
  output logic [NUM_WIN*TGT_W-1:0] win_tgt,
  output logic [NUM_WIN-1:0]       win_ws,
  output logic [NUM_WIN-1:0]       win_rs,
  output logic [NUM_WIN*BLK_W-1:0] win_lo,
  output logic [NUM_WIN*BLK_W-1:0] win_hi,
  output logic [TGT_W-1:0]         dflt_tgt
);
  import awr_pkg::*;

  localparam int GLB_IDX = NUM_WIN * 4;
  localparam int SEL_W   = REG_AW - 2;

  slot_e slot;
  assign slot = slot_e'(addr[1:0]);

  logic glb_wr;
  assign glb_wr = wr_en && (addr == REG_AW'(GLB_IDX));

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    if (i == 0) begin : g_fixed
      assign win_en[i]                   = 1'b1;
      assign win_tgt[i*TGT_W +: TGT_W]   = CFG_TGT;
      assign win_ws[i]                   = 1'b0;
      assign win_rs[i]                   = 1'b0;
      assign win_lo[i*BLK_W +: BLK_W]    = CFG_LO_BLK;
      assign win_hi[i*BLK_W +: BLK_W]    = CFG_HI_BLK;
    end else begin : g_prog
      logic             en_q, ws_q, rs_q;
      logic [TGT_W-1:0] tgt_q;
      logic [BLK_W-1:0] lo_q, hi_q;
      logic             sel;
      assign sel = wr_en && (addr[REG_AW-1:2] == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q  <= 1'b0;
          tgt_q <= '0;
          ws_q  <= 1'b0;
          rs_q  <= 1'b0;
          lo_q  <= '0;
          hi_q  <= '0;
        end else if (sel) begin
          case (slot)
            SLOT_CTRL: begin
              en_q  <= wdata[0];
              tgt_q <= wdata[TGT_LSB +: TGT_W];
            end
            SLOT_SEC: begin
              ws_q <= wdata[0];
              rs_q <= wdata[1];
            end
            SLOT_LO: lo_q <= wdata[4 +: BLK_W];
            default: hi_q <= wdata[4 +: BLK_W];
          endcase
        end
      end

      assign win_en[i]                 = en_q;
      assign win_tgt[i*TGT_W +: TGT_W] = tgt_q;
      assign win_ws[i]                 = ws_q;
      assign win_rs[i]                 = rs_q;
      assign win_lo[i*BLK_W +: BLK_W]  = lo_q;
      assign win_hi[i*BLK_W +: BLK_W]  = hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dflt_tgt <= '0;
    else if (glb_wr) dflt_tgt <= wdata[TGT_W-1:0];
  end

  always_comb begin
    int ri;
    ri    = int'(addr[REG_AW-1:2]);
    rdata = '0;
    if (ri < NUM_WIN) begin
      case (slot)
        SLOT_CTRL: begin
          rdata[0]                 = win_en[ri];
          rdata[TGT_LSB +: TGT_W]  = win_tgt[ri*TGT_W +: TGT_W];
        end
        SLOT_SEC: begin
          rdata[0] = win_ws[ri];
          rdata[1] = win_rs[ri];
        end
        SLOT_LO: rdata[4 +: BLK_W] = win_lo[ri*BLK_W +: BLK_W];
        default: rdata[4 +: BLK_W] = win_hi[ri*BLK_W +: BLK_W];
      endcase
    end else if (addr == REG_AW'(GLB_IDX)) begin
      rdata[TGT_W-1:0] = dflt_tgt;
    end
  end

endmodule

// File: rtl/awr_span_match.sv
module awr_span_match #(
  parameter int NUM_WIN = 8,
  parameter int BLK_W   = 28
) (
  input  logic [BLK_W-1:0]         blk,
  input  logic [NUM_WIN-1:0]       win_en,
  input  logic [NUM_WIN*BLK_W-1:0] win_lo,
  input  logic [NUM_WIN*BLK_W-1:0] win_hi,
  output logic [NUM_WIN-1:0]       hits
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    assign hits[i] = awr_pkg::blk_in_span(win_en[i],
                                          32'(win_lo[i*BLK_W +: BLK_W]),
                                          32'(win_hi[i*BLK_W +: BLK_W]),
                                          32'(blk));
  end
endmodule

// File: rtl/awr_low_first.sv
module awr_low_first #(
  parameter int NUM_WIN = 8,
  parameter int WIN_W   = 3
) (
  input  logic [NUM_WIN-1:0] hits,
  output logic               any,
  output logic [WIN_W-1:0]   idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) idx = WIN_W'(i);
    end
  end
endmodule

// File: rtl/addr_window_router.sv
module addr_window_router #(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 48,
  parameter int TGT_W   = 8,
  parameter int TGT_LSB = 4,
  parameter logic [TGT_W-1:0]    CFG_TGT    = 8'h0F,
  parameter logic [ADDR_W-21:0]  CFG_LO_BLK = 28'hF000000,
  parameter logic [ADDR_W-21:0]  CFG_HI_BLK = 28'hF00000F,
  localparam int BLK_W  = ADDR_W - 20,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int REG_AW = $clog2(NUM_WIN * 4 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [ADDR_W-1:0] dec_addr,
  output logic [TGT_W-1:0]  dec_target,
  output logic              dec_hit,
  output logic [WIN_W-1:0]  dec_win,
  output logic              dec_wr_secure,
  output logic              dec_rd_secure
);
  logic [NUM_WIN-1:0]       win_en, win_ws, win_rs, hits;
  logic [NUM_WIN*TGT_W-1:0] win_tgt;
  logic [NUM_WIN*BLK_W-1:0] win_lo, win_hi;
  logic [TGT_W-1:0]         dflt_tgt;
  logic [BLK_W-1:0]         dec_blk;
  logic                     unused_offset;

  assign dec_blk       = dec_addr[ADDR_W-1:20];
  assign unused_offset = ^dec_addr[19:0];

  awr_regfile #(
    .NUM_WIN(NUM_WIN), .BLK_W(BLK_W), .TGT_W(TGT_W), .TGT_LSB(TGT_LSB),
    .REG_AW(REG_AW), .CFG_TGT(CFG_TGT), .CFG_LO_BLK(CFG_LO_BLK), .CFG_HI_BLK(CFG_HI_BLK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .win_en(win_en), .win_tgt(win_tgt), .win_ws(win_ws),
    .win_rs(win_rs), .win_lo(win_lo), .win_hi(win_hi), .dflt_tgt(dflt_tgt)
  );

  awr_span_match #(.NUM_WIN(NUM_WIN), .BLK_W(BLK_W)) u_match (
    .blk(dec_blk), .win_en(win_en), .win_lo(win_lo), .win_hi(win_hi), .hits(hits)
  );

  awr_low_first #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_pick (
    .hits(hits), .any(dec_hit), .idx(dec_win)
  );

  always_comb begin
    int w;
    w = int'(dec_win);
    if (dec_hit) begin
      dec_target    = win_tgt[w*TGT_W +: TGT_W];
      dec_wr_secure = win_ws[w];
      dec_rd_secure = win_rs[w];
    end else begin
      dec_target    = dflt_tgt;
      dec_wr_secure = 1'b0;
      dec_rd_secure = 1'b0;
    end
  end

endmodule

// File: rtl/awr_checker.sv
module awr_checker #(
  parameter int NUM_WIN = 8,
  parameter int BLK_W   = 28,
  parameter int TGT_W   = 8,
  parameter int WIN_W   = 3,
  parameter int REG_AW  = 6,
  parameter logic [TGT_W-1:0] CFG_TGT    = 8'h0F,
  parameter logic [BLK_W-1:0] CFG_LO_BLK = 28'hF000000,
  parameter logic [BLK_W-1:0] CFG_HI_BLK = 28'hF00000F
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_WIN-1:0]       hits,
  input logic [NUM_WIN-1:0]       win_en,
  input logic [NUM_WIN*BLK_W-1:0] win_lo,
  input logic [NUM_WIN*BLK_W-1:0] win_hi,
  input logic [TGT_W-1:0]         dflt_tgt,
  input logic [BLK_W-1:0]         dec_blk,
  input logic                     dec_hit,
  input logic [WIN_W-1:0]         dec_win,
  input logic [TGT_W-1:0]         dec_target,
  input logic                     dec_wr_secure,
  input logic                     dec_rd_secure,
  input logic                     reg_wr_en,
  input logic [REG_AW-1:0]        reg_addr,
  input logic [TGT_W-1:0]         glb_wdata
);
  logic [NUM_WIN-1:0] below_mask;
  assign below_mask = (NUM_WIN'(1) << dec_win) - NUM_WIN'(1);

  p_hit_any_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit == (|hits));

  p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> (hits[dec_win] && ((hits & below_mask) == '0)));

  p_miss_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> (dec_target == dflt_tgt && !dec_wr_secure && !dec_rd_secure && dec_win == '0));

  p_cfg_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_blk >= CFG_LO_BLK && dec_blk <= CFG_HI_BLK) |->
      (dec_hit && dec_win == '0 && dec_target == CFG_TGT));

  p_glb_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == REG_AW'(NUM_WIN * 4)) |=> (dflt_tgt == $past(glb_wdata)));

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win_props
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en[i] |-> !hits[i]);
    p_inverted_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hi[i*BLK_W +: BLK_W] < win_lo[i*BLK_W +: BLK_W]) |-> !hits[i]);
  end
endmodule

bind addr_window_router awr_checker #(
  .NUM_WIN(NUM_WIN), .BLK_W(BLK_W), .TGT_W(TGT_W), .WIN_W(WIN_W), .REG_AW(REG_AW),
  .CFG_TGT(CFG_TGT), .CFG_LO_BLK(CFG_LO_BLK), .CFG_HI_BLK(CFG_HI_BLK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hits(hits), .win_en(win_en), .win_lo(win_lo),
  .win_hi(win_hi), .dflt_tgt(dflt_tgt), .dec_blk(dec_blk), .dec_hit(dec_hit),
  .dec_win(dec_win), .dec_target(dec_target), .dec_wr_secure(dec_wr_secure),
  .dec_rd_secure(dec_rd_secure), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .glb_wdata(reg_wdata[TGT_W-1:0])
);

// File: tb/addr_window_router_tb_top.sv
`timescale 1ns/1ps
module addr_window_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [47:0] dec_addr = '0;
  logic [7:0]  dec_target;
  logic        dec_hit;
  logic [2:0]  dec_win;
  logic        dec_wr_secure, dec_rd_secure;

  always #2.5 clk = ~clk;

  addr_window_router dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_addr(dec_addr),
    .dec_target(dec_target), .dec_hit(dec_hit), .dec_win(dec_win),
    .dec_wr_secure(dec_wr_secure), .dec_rd_secure(dec_rd_secure)
  );

  typedef struct {
    bit          is_rd;
    logic [31:0] rd;
    logic [13:0] dec;
    string       tag;
  } item_t;

  item_t q[$];
  event  go;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // Monitor: pops every expected item and compares with the live outputs.
  initial begin
    forever begin
      @(go);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (it.is_rd) begin
          if (reg_rdata !== it.rd) begin
            errors++;
            $display("FAIL %s rdata got %h exp %h", it.tag, reg_rdata, it.rd);
          end
        end else begin
          logic [13:0] got;
          got = {dec_target, dec_hit, dec_win, dec_wr_secure, dec_rd_secure};
          if (got !== it.dec) begin
            errors++;
            $display("FAIL %s {tgt,hit,win,ws,rs} got %h exp %h", it.tag, got, it.dec);
          end
        end
      end
    end
  end

  function automatic int widx(int w, int slot);
    return w * 4 + slot;
  endfunction

  function automatic logic [31:0] bound(logic [27:0] blk);
    return {blk, 4'h0};
  endfunction

  task automatic push_dec(logic [7:0] t, logic h, logic [2:0] w, logic ws, logic rs, string tag);
    item_t it;
    it.is_rd = 0; it.rd = '0; it.dec = {t, h, w, ws, rs}; it.tag = tag;
    q.push_back(it);
    -> go;
    #1;
  endtask

  task automatic chk_dec(logic [47:0] a, logic [7:0] t, logic h, logic [2:0] w,
                         logic ws, logic rs, string tag);
    @(negedge clk);
    dec_addr = a;
    #1;
    push_dec(t, h, w, ws, rs, tag);
  endtask

  task automatic chk_rd(int idx, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    reg_addr = 6'(idx);
    #1;
    it.is_rd = 1; it.rd = exp; it.dec = '0; it.tag = tag;
    q.push_back(it);
    -> go;
    #1;
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 6'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd(widx(0, 0), 32'h0000_00F1, "R1 win0 ctrl");
    chk_rd(widx(0, 2), 32'hF000_0000, "R1 win0 lo");
    chk_rd(widx(0, 3), 32'hF000_00F0, "R1 win0 hi");
    chk_rd(widx(1, 0), 32'h0, "R1 win1 ctrl");
    chk_rd(widx(7, 0), 32'h0, "R1 win7 ctrl");
    chk_rd(32, 32'h0, "R1 fallback");
    chk_dec(48'hF000_0050_0000, 8'h0F, 1, 3'd0, 0, 0, "R9 cfg hit");
    chk_dec(48'h0000_1000_0000, 8'h00, 0, 3'd0, 0, 0, "R5 miss reset");

    // R2 programming with junk in unimplemented bits
    wr(widx(1, 2), 32'h0000_001F);
    wr(widx(1, 3), 32'h0000_003A);
    wr(widx(1, 0), 32'hFFFF_F22F);
    chk_rd(widx(1, 0), 32'h0000_0221, "R2 ctrl mask");
    chk_rd(widx(1, 2), bound(28'h1), "R2 lo mask");
    chk_rd(widx(1, 3), bound(28'h3), "R2 hi mask");

    // R4 inclusive bounds
    chk_dec(48'h0000_0010_0000, 8'h22, 1, 3'd1, 0, 0, "R4 first byte");
    chk_dec(48'h0000_003F_FFFF, 8'h22, 1, 3'd1, 0, 0, "R4 last byte");
    chk_dec(48'h0000_0040_0000, 8'h00, 0, 3'd0, 0, 0, "R4 above span");
    chk_dec(48'h0000_000F_FFFF, 8'h00, 0, 3'd0, 0, 0, "R4 below span");

    // R5 fallback destination
    wr(32, 32'hFFFF_FFAB);
    chk_rd(32, 32'h0000_00AB, "R2 fallback mask");
    chk_dec(48'h0000_0040_0000, 8'hAB, 0, 3'd0, 0, 0, "R5 fallback");

    // R8 security flags
    wr(widx(1, 1), 32'hFFFF_FFFE);
    chk_rd(widx(1, 1), 32'h0000_0002, "R2 sec mask");
    chk_dec(48'h0000_0020_0000, 8'h22, 1, 3'd1, 0, 1, "R8 read secure");
    wr(widx(1, 1), 32'h1);
    chk_dec(48'h0000_0020_0000, 8'h22, 1, 3'd1, 1, 0, "R8 write secure");
    chk_dec(48'h0000_0050_0000, 8'hAB, 0, 3'd0, 0, 0, "R5 miss no secure");

    // R3 disable
    wr(widx(1, 0), 32'h0000_0220);
    chk_dec(48'h0000_0010_0000, 8'hAB, 0, 3'd0, 0, 0, "R3 disabled");

    // R6 overlap priority
    wr(widx(2, 2), bound(28'h2));
    wr(widx(2, 3), bound(28'h10));
    wr(widx(2, 0), 32'h0000_0331);
    wr(widx(5, 2), bound(28'h0));
    wr(widx(5, 3), bound(28'h20));
    wr(widx(5, 0), 32'h0000_0551);
    wr(widx(1, 0), 32'h0000_0221);
    chk_dec(48'h0000_0020_0000, 8'h22, 1, 3'd1, 1, 0, "R6 win1 over 2,5");
    chk_dec(48'h0000_0080_0000, 8'h33, 1, 3'd2, 0, 0, "R6 win2 over 5");
    chk_dec(48'h0000_0000_0000, 8'h55, 1, 3'd5, 0, 0, "R6 win5 alone");
    chk_dec(48'h0000_0210_0000, 8'hAB, 0, 3'd0, 0, 0, "R6 past all");

    // R7 inverted bounds
    wr(widx(3, 2), bound(28'h100));
    wr(widx(3, 3), bound(28'h0FF));
    wr(widx(3, 0), 32'h0000_0441);
    chk_dec(48'h0000_1000_0000, 8'hAB, 0, 3'd0, 0, 0, "R7 at lo");
    chk_dec(48'h0000_0FF0_0000, 8'hAB, 0, 3'd0, 0, 0, "R7 at hi");

    // R9 window 0 write protection
    wr(widx(0, 0), 32'h0);
    wr(widx(0, 2), 32'h0);
    wr(widx(0, 1), 32'h3);
    chk_rd(widx(0, 0), 32'h0000_00F1, "R9 ctrl kept");
    chk_rd(widx(0, 2), 32'hF000_0000, "R9 lo kept");
    chk_rd(widx(0, 1), 32'h0, "R9 sec kept");
    chk_dec(48'hF000_00FF_FFFF, 8'h0F, 1, 3'd0, 0, 0, "R9 cfg top");

    // R10 write visible only after the edge
    @(negedge clk);
    dec_addr = 48'h0000_0300_0000;
    reg_wr_en = 1'b1; reg_addr = 6'd32; reg_wdata = 32'h0000_005C;
    #1;
    push_dec(8'hAB, 0, 3'd0, 0, 0, "R10 before edge");
    @(negedge clk);
    reg_wr_en = 1'b0;
    #1;
    push_dec(8'h5C, 0, 3'd0, 0, 0, "R10 after edge");

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule